// File: doc/BRIEF.md
# Carrier-Cycle Modulation Shaper

This block takes an already line-encoded bit stream and turns it into an amplitude control that updates once per RF carrier cycle. A carrier tick input marks each carrier cycle. A bit-boundary strobe, which arrives together with a tick, marks the first carrier cycle of each new bit. The encoded level and a 2-bit mode field are sampled only at that strobe. The single output drives the high/low amplitude switch that sits downstream.

Four modes are available. In ASK the bit level passes straight through. In FSK each bit is made of fixed groups of carrier cycles whose size depends on the bit value. In the two PSK modes a subcarrier toggles on every carrier cycle, and a phase inversion is made by holding the level for one extra cycle at a bit boundary. The bit-rate divider and the line encoder are outside the block. FSK needs a bit period that is a multiple of 40 carrier cycles, so that every bit holds whole groups.

Top module: `carrierModShaper`

## Requirements
- R1: While reset is asserted and right after it is released, `ampOut` is 0, the latched mode is ASK and the remembered previous bit level is 0.
- R2: Mode encoding at `modeSel`: 2'b00 ASK, 2'b01 FSK, 2'b10 PSK-on-change, 2'b11 PSK-on-one. In ASK, every tick of a bit sets `ampOut` to the level sampled at that bit's strobe.
- R3: In FSK, a bit of level 1 gives repeating groups of 10 ticks: 5 ticks high, then 5 ticks low. The n-th tick of the bit (n = 0 at the strobe) is high when n mod 10 < 5.
- R4: In FSK, a bit of level 0 gives repeating groups of 8 ticks: 4 high, then 4 low. Tick n is high when n mod 8 < 4.
- R5: In FSK, the group count restarts at every strobe, even when the previous group is unfinished, so each bit starts with a high half. A 40-tick bit holds exactly 4 groups for a 1 and 5 groups for a 0.
- R6: In both PSK modes, `ampOut` inverts on every tick that carries no strobe.
- R7: In PSK-on-change, at a strobe tick `ampOut` holds its value when the new level differs from the previous bit's level, and inverts otherwise.
- R8: In PSK-on-one, at a strobe tick `ampOut` holds its value when the new level is 1, and inverts when it is 0.
- R9: `modeSel` and `encLevel` have no effect on ticks without a strobe. Mode and level change only at a bit boundary.
- R10: On a cycle with `carrierTick` low, `ampOut` and all internal state hold, and a `bitStrobe` on that cycle is ignored.
- R11: The previous bit level used by R7 is updated at every strobe in every mode, so the first PSK bit after another mode compares against the last bit sent.
- R12: `ampOut` is registered. It takes its new value on the clock edge that samples the tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| carrierTick | input | 1 | One-cycle pulse per RF carrier cycle |
| bitStrobe | input | 1 | First carrier cycle of a new bit; valid only with a tick |
| encLevel | input | 1 | Encoded data level, sampled at the strobe |
| modeSel | input | 2 | Modulation mode, sampled at the strobe (encoding in R2) |
| ampOut | output | 1 | Amplitude control: 1 high, 0 low |

## Verification
The bench goes after the points where the group counter and the phase state meet a bit boundary.

An FSK 1 is cut short after seven ticks and followed by a 0. A design that kept counting through the boundary would start the 0 in its low half.

PSK runs cover equal, differing, one and zero neighbours, and also a switch into PSK straight after ASK. A design that tracked the previous level only in PSK, or that mixed up the two inversion rules, would toggle where it should hold.

Idle cycles with a stray strobe, and mode or level changes in the middle of a bit, are sent as well. A design that sampled its inputs outside the strobe tick would change group size or mode partway through a bit.

// File: rtl/shaperPkg.sv
package shaperPkg;

  typedef enum logic [1:0] {
    MODE_ASK     = 2'b00,
    MODE_FSK     = 2'b01,
    MODE_PSK_CHG = 2'b10,
    MODE_PSK_ONE = 2'b11
  } modeE;

  // strobes from control to datapath, valid in the tick cycle
  typedef struct packed {
    logic advance;   // a carrier tick is present
    logic restart;   // this tick opens a new bit
    logic invert;    // PSK: hold level to shift phase
    logic level;     // bit level in force for this tick
    modeE mode;      // mode in force for this tick
  } ctlBusT;

endpackage

// File: rtl/shaperCtrl.sv
module shaperCtrl
  import shaperPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       carrierTick,
  input  logic       bitStrobe,
  input  logic       encLevel,
  input  logic [1:0] modeSel,
  output ctlBusT     ctlBus
);

  modeE curMode;
  logic curLevel;     // level of the bit being sent (previous bit at a strobe)
  logic atBoundary;
  modeE newMode;
  logic invertNow;

  assign atBoundary = carrierTick & bitStrobe;
  assign newMode    = modeE'(modeSel);

  always_comb begin
    invertNow = 1'b0;
    if (atBoundary) begin
      unique case (newMode)
        MODE_PSK_CHG: invertNow = (encLevel != curLevel);
        MODE_PSK_ONE: invertNow = encLevel;
        default:      invertNow = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode  <= MODE_ASK;
      curLevel <= 1'b0;
    end else if (atBoundary) begin
      curMode  <= newMode;
      curLevel <= encLevel;
    end
  end

  always_comb begin
    ctlBus.advance = carrierTick;
    ctlBus.restart = atBoundary;
    ctlBus.invert  = invertNow;
    ctlBus.level   = atBoundary ? encLevel : curLevel;
    ctlBus.mode    = atBoundary ? newMode  : curMode;
  end

endmodule

// File: rtl/shaperData.sv
module shaperData
  import shaperPkg::*;
#(
  parameter int ONE_GROUP  = 10,
  parameter int ZERO_GROUP = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  ctlBusT ctlBus,
  output logic   ampOut
);

  localparam int MAX_GROUP = (ONE_GROUP > ZERO_GROUP) ? ONE_GROUP : ZERO_GROUP;
  localparam int CNT_W     = $clog2(MAX_GROUP);
  localparam int GROUP_LEN [2] = '{ZERO_GROUP, ONE_GROUP};

  logic [CNT_W-1:0] lastOf [2];
  logic [CNT_W-1:0] halfOf [2];

  for (genvar g = 0; g < 2; g++) begin : gSize
    assign lastOf[g] = CNT_W'(GROUP_LEN[g] - 1);
    assign halfOf[g] = CNT_W'(GROUP_LEN[g] / 2);
  end

  logic [CNT_W-1:0] grpCnt;
  logic [CNT_W-1:0] nextIdx;
  logic             nextAmp;
  logic             sel;

  assign sel = ctlBus.level;

  always_comb begin
    if (ctlBus.restart)                nextIdx = '0;
    else if (grpCnt >= lastOf[sel])    nextIdx = '0;
    else                               nextIdx = grpCnt + 1'b1;
  end

  always_comb begin
    unique case (ctlBus.mode)
      MODE_ASK: nextAmp = ctlBus.level;
      MODE_FSK: nextAmp = (nextIdx < halfOf[sel]);
      default:  nextAmp = ctlBus.invert ? ampOut : ~ampOut;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grpCnt <= '0;
      ampOut <= 1'b0;
    end else if (ctlBus.advance) begin
      grpCnt <= nextIdx;
      ampOut <= nextAmp;
    end
  end

endmodule

// File: rtl/carrierModShaper.sv
module carrierModShaper
  import shaperPkg::*;
#(
  parameter int ONE_GROUP  = 10,
  parameter int ZERO_GROUP = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       carrierTick,
  input  logic       bitStrobe,
  input  logic       encLevel,
  input  logic [1:0] modeSel,
  output logic       ampOut
);

  ctlBusT ctlBus;

  shaperCtrl ctl (
    .clk        (clk),
    .rstN       (rstN),
    .carrierTick(carrierTick),
    .bitStrobe  (bitStrobe),
    .encLevel   (encLevel),
    .modeSel    (modeSel),
    .ctlBus     (ctlBus)
  );

  shaperData #(
    .ONE_GROUP (ONE_GROUP),
    .ZERO_GROUP(ZERO_GROUP)
  ) dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctlBus(ctlBus),
    .ampOut(ampOut)
  );

endmodule

// File: rtl/shaperChk.sv
module shaperChk (
  input logic       clk,
  input logic       rstN,
  input logic       carrierTick,
  input logic       bitStrobe,
  input logic       encLevel,
  input logic [1:0] modeSel,
  input logic [1:0] latchedMode,
  input logic       ampOut
);

  // R1
  reset_low_chk: assert property (@(posedge clk) $rose(rstN) |-> !ampOut);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !carrierTick |=> $stable(ampOut));

  // R2
  ask_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (carrierTick && bitStrobe && modeSel == 2'b00) |=> ampOut == $past(encLevel));

  // R5
  fsk_start_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (carrierTick && bitStrobe && modeSel == 2'b01) |=> ampOut);

  // R6
  psk_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (carrierTick && !bitStrobe && latchedMode[1]) |=> ampOut != $past(ampOut));

  // R8
  psk_one_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (carrierTick && bitStrobe && modeSel == 2'b11 && encLevel) |=> $stable(ampOut));

  // R8
  psk_zero_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (carrierTick && bitStrobe && modeSel == 2'b11 && !encLevel) |=> !$stable(ampOut));

endmodule

bind carrierModShaper shaperChk chk (
  .clk        (clk),
  .rstN       (rstN),
  .carrierTick(carrierTick),
  .bitStrobe  (bitStrobe),
  .encLevel   (encLevel),
  .modeSel    (modeSel),
  .latchedMode(ctlBus.mode),
  .ampOut     (ampOut)
);

// File: tb/carrierModShaper_test.sv
`timescale 1ns/1ps
module carrierModShaper_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       carrierTick = 1'b0;
  logic       bitStrobe = 1'b0;
  logic       encLevel = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       ampOut;

  typedef struct {
    logic  expAmp;
    string tag;
  } expItemT;

  expItemT expQ[$];
  int  checks = 0;
  int  fails = 0;
  bit  done = 0;
  logic modelAmp = 1'b0;
  logic modelPrev = 1'b0;

  always #2.5 clk = ~clk;

  carrierModShaper uut (
    .clk(clk), .rstN(rstN), .carrierTick(carrierTick), .bitStrobe(bitStrobe),
    .encLevel(encLevel), .modeSel(modeSel), .ampOut(ampOut)
  );

  task automatic checkOne(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: ampOut=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: one expected item per clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItemT it;
        it = expQ.pop_front();
        checkOne(ampOut, it.expAmp, it.tag);
      end
    end
  end

  // idle cycle with a stray strobe and junk inputs: nothing may change
  task automatic idleCycle();
    expItemT it;
    @(negedge clk);
    carrierTick = 1'b0;
    bitStrobe   = 1'b1;
    encLevel    = ~encLevel;
    modeSel     = ~modeSel;
    it.expAmp = modelAmp;
    it.tag    = "R10";
    expQ.push_back(it);
  endtask

  // one bit of nTicks carrier ticks; gaps inserts idle cycles, junk scrambles inputs mid-bit
  task automatic sendBit(input logic lvl, input logic [1:0] mode, input int nTicks,
                         input bit gaps, input bit junk);
    for (int k = 0; k < nTicks; k++) begin
      expItemT it;
      logic inv;
      if (gaps && (k % 3 == 1)) idleCycle();
      @(negedge clk);
      carrierTick = 1'b1;
      bitStrobe   = (k == 0);
      if (k == 0) begin
        encLevel = lvl;
        modeSel  = mode;
      end else if (junk) begin
        encLevel = ~lvl;
        modeSel  = mode ^ 2'b01;
      end else begin
        encLevel = lvl;
        modeSel  = mode;
      end
      case (mode)
        2'b00: begin it.expAmp = lvl; it.tag = junk ? "R9" : "R2"; end
        2'b01: begin
          if (lvl) it.expAmp = ((k % 10) < 5);
          else     it.expAmp = ((k % 8) < 4);
          it.tag = junk ? "R9" : (k == 0 ? "R5" : (lvl ? "R3" : "R4"));
        end
        default: begin
          if (k == 0) begin
            inv = (mode == 2'b10) ? (lvl != modelPrev) : lvl;
            it.expAmp = inv ? modelAmp : ~modelAmp;
            it.tag = (mode == 2'b10) ? "R7" : "R8";
          end else begin
            it.expAmp = ~modelAmp;
            it.tag = junk ? "R9" : "R6";
          end
        end
      endcase
      modelAmp = it.expAmp;
      expQ.push_back(it);
    end
    modelPrev = lvl;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOne(ampOut, 1'b0, "R1");
    rstN = 1'b1;
    @(negedge clk);
    checkOne(ampOut, 1'b0, "R1");

    // R2 ASK, R12 registered timing via monitor sampling
    sendBit(1'b1, 2'b00, 5, 0, 0);
    sendBit(1'b0, 2'b00, 4, 1, 0);
    sendBit(1'b1, 2'b00, 4, 0, 1);
    // R3 R4 R5 FSK full 40-tick bits
    sendBit(1'b1, 2'b01, 40, 0, 0);
    sendBit(1'b0, 2'b01, 40, 0, 0);
    sendBit(1'b1, 2'b01, 40, 1, 0);
    // R5 group cut short, then restart
    sendBit(1'b1, 2'b01, 7, 0, 0);
    sendBit(1'b0, 2'b01, 40, 0, 1);
    sendBit(1'b0, 2'b01, 40, 0, 0);
    // R11 last ASK bit is 1, then PSK-on-change with equal level
    sendBit(1'b1, 2'b00, 3, 0, 0);
    sendBit(1'b1, 2'b10, 6, 0, 0);
    sendBit(1'b0, 2'b10, 6, 1, 0);
    sendBit(1'b0, 2'b10, 6, 0, 1);
    sendBit(1'b1, 2'b10, 6, 0, 0);
    sendBit(1'b1, 2'b10, 5, 0, 0);
    // R8 PSK-on-one
    sendBit(1'b1, 2'b11, 6, 0, 0);
    sendBit(1'b1, 2'b11, 6, 1, 0);
    sendBit(1'b0, 2'b11, 6, 0, 1);
    sendBit(1'b0, 2'b11, 5, 0, 0);
    sendBit(1'b1, 2'b11, 6, 0, 0);
    // R11 PSK-on-change after PSK-on-one and FSK
    sendBit(1'b0, 2'b01, 8, 0, 0);
    sendBit(1'b1, 2'b10, 6, 0, 0);
    sendBit(1'b0, 2'b00, 3, 0, 0);

    @(negedge clk);
    carrierTick = 1'b0;
    bitStrobe   = 1'b0;
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R12: %0d results missing, expected 0", expQ.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule